// File: doc/BRIEF.md
# Runtime-Loadable 3x3 Image Filter

This block filters small square image blocks with a 3x3 kernel that software can replace at any time between blocks. A single 16-bit word stream carries two kinds of message: pixel words, flagged as data, and coefficient words, flagged as kernel. Nine coefficient words make a complete kernel, which is 18 bytes. That short reload is the whole task definition, so changing the filter needs no new hardware image and no compile step. The typical kernels detect edges: Laplacian, Sobel and sharpening.

A host cuts its image into blocks of `BLK_W` x `BLK_H` pixels. It sends each block in raster order and reads back one filtered pixel for every input pixel, in the same order. Each result is the sum of nine signed products over the pixel's 3x3 neighbourhood. Positions outside the block count as zero. The sum is arithmetically shifted right by `shift_amt` and clamped to 0..255. Both streams use valid/ready. A word moves only on a clock edge where valid and ready are both high. After raising valid, a sender holds the word steady until it is taken. The filter holds `out_data` and `out_last` steady while `out_ready` is low. A kernel load that arrives while a block is in flight is deferred: `in_ready` stays low for it until the block's last result has left.

Top module: `kernel3_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The kernel is the identity: centre tap 1, all other taps 0, so a block filtered with `shift_amt` = 0 comes back unchanged.
- R2: A word accepted with `in_is_coef` = 1 is a signed 16-bit coefficient written to the next tap. Taps fill in raster order: tap 0 is top-left, tap 4 is the centre, tap 8 is bottom-right. After tap 8 the next word goes to tap 0 again. Any accepted pixel word restarts the write position at tap 0.
- R3: A block is `BLK_W*BLK_H` words accepted with `in_is_coef` = 0, in raster order. Bits [7:0] carry the unsigned pixel and bits [15:8] are ignored.
- R4: The sum for the pixel at column x, row y is the total over r,c in 0..2 of tap[r*3+c] times the pixel at (x+c-1, y+r-1). A pixel outside the block reads as 0.
- R5: The 29-bit signed sum is arithmetically shifted right by `shift_amt` (0..15). Below 0 the result is 0, above 255 it is 255, and otherwise it is the value itself.
- R6: Results leave in raster order, one per input pixel. `out_last` is 1 exactly on the final result of each block.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values on the next cycle.
- R8: `in_ready` is 0 from the acceptance of a block's last pixel until that block's last result is accepted. A coefficient word is never accepted while part of a block has been received.
- R9: A kernel change takes effect only for blocks whose first pixel is accepted after the change. A block in flight is filtered entirely with the kernel it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_amt | input | SH_W | Right-shift applied to each sum; held steady during a block |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_is_coef | input | 1 | 1: word is a coefficient, 0: word is a pixel |
| in_data | input | COEF_W | Coefficient, or pixel in bits [PIX_W-1:0] |
| out_valid | output | 1 | Result pixel valid |
| out_ready | input | 1 | Receiver takes the result |
| out_data | output | PIX_W | Filtered, scaled and clamped pixel |
| out_last | output | 1 | Marks the final result of a block |

## Verification
The bound checker watches the stream rules on every cycle. It checks that a stalled result holds its value, and that input is shut while results are pending. It also checks that coefficient words arrive only between blocks, and that the end-of-block mark falls on exactly the right result count. These follow from the port handshakes alone. The arithmetic needs the bench's scenarios: correct taps against their neighbours, zero padding at all four edges, and the shift and both clamps. So do the tap write order, including wrap-around and restart on pixel data, the identity kernel after reset, and a deferred kernel leaving the block in flight untouched.

// File: rtl/kf_pkg.sv
package kf_pkg;
  localparam int TAPS       = 9;
  localparam int CENTER_TAP = 4;
  localparam int TAP_PTR_W  = $clog2(TAPS);

  typedef enum logic {
    ST_FILL = 1'b0,
    ST_RUN  = 1'b1
  } kf_state_e;
endpackage

// File: rtl/kf_coef_bank.sv
module kf_coef_bank
  import kf_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [COEF_W-1:0]        wr_data,
  input  logic                     ptr_clr,
  output logic [TAPS*COEF_W-1:0]   coef_flat
);
  logic [TAP_PTR_W-1:0] ptr;
  logic [COEF_W-1:0]    taps [TAPS];

  // write position: advances per coefficient, wraps after the last tap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr <= (ptr == TAP_PTR_W'(TAPS-1)) ? '0 : ptr + 1'b1;
    end else if (ptr_clr) begin
      ptr <= '0;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        taps[t] <= (t == CENTER_TAP) ? COEF_W'(1) : '0;
      end else if (wr_en && ptr == TAP_PTR_W'(t)) begin
        taps[t] <= wr_data;
      end
    end
    assign coef_flat[t*COEF_W +: COEF_W] = taps[t];
  end
endmodule

// File: rtl/kf_block_store.sv
module kf_block_store
  import kf_pkg::*;
#(
  parameter int BW    = 8,
  parameter int BH    = 8,
  parameter int PIX_W = 8,
  localparam int N    = BW * BH,
  localparam int AW   = $clog2(N),
  localparam int CW   = $clog2(BW),
  localparam int RW   = $clog2(BH)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [PIX_W-1:0]       wr_pix,
  input  logic [CW-1:0]          col,
  input  logic [RW-1:0]          row,
  output logic [TAPS*PIX_W-1:0]  win_flat
);
  logic [PIX_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_pix;
  end

  // 3x3 window around (col,row); neighbours outside the block read as zero
  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      logic [PIX_W-1:0] tap_pix;
      always_comb begin : p_rd
        int rr;
        int cc;
        rr = int'(row) + r - 1;
        cc = int'(col) + c - 1;
        if (rr >= 0 && rr < BH && cc >= 0 && cc < BW)
          tap_pix = mem[AW'(rr * BW + cc)];
        else
          tap_pix = '0;
      end
      assign win_flat[(r*3+c)*PIX_W +: PIX_W] = tap_pix;
    end
  end
endmodule

// File: rtl/kf_mac.sv
module kf_mac
  import kf_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int SH_W   = 4,
  localparam int PW    = COEF_W + PIX_W + 1,
  localparam int ACC_W = PW + TAP_PTR_W
) (
  input  logic [TAPS*PIX_W-1:0]  win_flat,
  input  logic [TAPS*COEF_W-1:0] coef_flat,
  input  logic [SH_W-1:0]        shift_amt,
  output logic [PIX_W-1:0]       pix_out
);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [PW-1:0]    prods [TAPS];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scaled;

  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    assign prods[t] = $signed(coef_flat[t*COEF_W +: COEF_W])
                    * $signed({1'b0, win_flat[t*PIX_W +: PIX_W]});
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) acc = acc + ACC_W'(prods[t]);
  end

  assign scaled = acc >>> shift_amt;

  always_comb begin
    if (scaled < 0)            pix_out = '0;
    else if (scaled > PIX_MAX) pix_out = '1;
    else                       pix_out = scaled[PIX_W-1:0];
  end
endmodule

// File: rtl/kernel3_filter.sv
module kernel3_filter
  import kf_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int BLK_H  = 8,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 16,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SH_W-1:0]   shift_amt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_coef,
  input  logic [COEF_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_data,
  output logic              out_last
);
  localparam int N  = BLK_W * BLK_H;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(BLK_W);
  localparam int RW = $clog2(BLK_H);

  kf_state_e        state;
  logic [AW-1:0]    pix_cnt;
  logic [CW-1:0]    rcol;
  logic [RW-1:0]    rrow;
  logic             issued_all;
  logic             ov;
  logic [PIX_W-1:0] od;
  logic             ol;

  logic                     pix_acc, coef_acc, load, last_pos, col_last;
  logic [TAPS*COEF_W-1:0]   coef_flat;
  logic [TAPS*PIX_W-1:0]    win_flat;
  logic [PIX_W-1:0]         mac_pix;

  // coefficients only between blocks; nothing while results are pending
  assign in_ready = (state == ST_FILL) && (!in_is_coef || pix_cnt == '0);
  assign pix_acc  = in_valid && in_ready && !in_is_coef;
  assign coef_acc = in_valid && in_ready && in_is_coef;

  assign col_last = (rcol == CW'(BLK_W-1));
  assign last_pos = col_last && (rrow == RW'(BLK_H-1));
  assign load     = (state == ST_RUN) && !issued_all && (!ov || out_ready);

  kf_coef_bank #(.COEF_W(COEF_W)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (coef_acc),
    .wr_data   (in_data),
    .ptr_clr   (pix_acc),
    .coef_flat (coef_flat)
  );

  kf_block_store #(.BW(BLK_W), .BH(BLK_H), .PIX_W(PIX_W)) u_store (
    .clk      (clk),
    .wr_en    (pix_acc),
    .wr_addr  (pix_cnt),
    .wr_pix   (in_data[PIX_W-1:0]),
    .col      (rcol),
    .row      (rrow),
    .win_flat (win_flat)
  );

  kf_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .SH_W(SH_W)) u_mac (
    .win_flat  (win_flat),
    .coef_flat (coef_flat),
    .shift_amt (shift_amt),
    .pix_out   (mac_pix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_FILL;
      pix_cnt    <= '0;
      rcol       <= '0;
      rrow       <= '0;
      issued_all <= 1'b0;
      ov         <= 1'b0;
      od         <= '0;
      ol         <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (pix_acc) begin
            if (pix_cnt == AW'(N-1)) begin
              pix_cnt    <= '0;
              rcol       <= '0;
              rrow       <= '0;
              issued_all <= 1'b0;
              state      <= ST_RUN;
            end else begin
              pix_cnt <= pix_cnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (load) begin
            od <= mac_pix;
            ol <= last_pos;
            ov <= 1'b1;
            if (last_pos) begin
              issued_all <= 1'b1;
            end else if (col_last) begin
              rcol <= '0;
              rrow <= rrow + 1'b1;
            end else begin
              rcol <= rcol + 1'b1;
            end
          end else if (out_ready) begin
            ov <= 1'b0;
          end
          if (issued_all && ov && out_ready) begin
            issued_all <= 1'b0;
            state      <= ST_FILL;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  assign out_valid = ov;
  assign out_data  = od;
  assign out_last  = ol;
endmodule

// File: rtl/kf_chk.sv
module kf_chk #(
  parameter int BW = 8,
  parameter int BH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_is_coef,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  localparam int N = BW * BH;

  int unsigned pix_seen;
  int unsigned out_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_seen <= 0;
      out_seen <= 0;
    end else begin
      if (in_valid && in_ready && !in_is_coef)
        pix_seen <= (pix_seen == N-1) ? 0 : pix_seen + 1;
      if (out_valid && out_ready)
        out_seen <= (out_seen == N-1) ? 0 : out_seen + 1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7

  AST_IN_SHUT_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R8

  AST_COEF_BETWEEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_is_coef |-> pix_seen == 0 && out_seen == 0); // R8

  AST_PIX_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_is_coef |-> out_seen == 0); // R8

  AST_LAST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_seen == N-1))); // R6
endmodule

bind kernel3_filter kf_chk #(.BW(BLK_W), .BH(BLK_H)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_is_coef (in_is_coef),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last)
);

// File: tb/sim_kernel3_filter.sv
module sim_kernel3_filter;
  localparam int BW = 8;
  localparam int BH = 8;
  localparam int N  = BW * BH;
  localparam int NV = 6;

  // kernel, shift, image seed, stall pattern per vector
  localparam int KTAB [NV][9] = '{
    '{ 0, -1,  0, -1,  4, -1,  0, -1,  0},
    '{-1,  0,  1, -2,  0,  2, -1,  0,  1},
    '{ 1,  1,  1,  1,  1,  1,  1,  1,  1},
    '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{ 0, -1,  0, -1,  5, -1,  0, -1,  0}
  };
  localparam int SHTAB [NV] = '{0, 1, 3, 15, 0, 0};
  localparam int SEEDT [NV] = '{1, 2, 3, 4, 5, 6};
  localparam int STALT [NV] = '{0, 1, 0, 1, 1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  shift_amt = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_coef = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  int img [N];
  int expv [N];
  int kref [9];
  int kptr = 0;
  bit coll_done;

  always #5 clk = ~clk;

  kernel3_filter u0 (
    .clk(clk), .rst_n(rst_n), .shift_amt(shift_amt),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_coef(in_is_coef), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  function automatic void make_img(input int seed);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++)
        img[y*BW+x] = (x*37 + y*91 + seed*13 + x*y*7) % 256;
  endfunction

  // R4 R5: reference sum, shift and clamp
  function automatic void make_exp(input int sh);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        int s = 0;
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++) begin
            int yy = y + r - 1;
            int xx = x + c - 1;
            if (yy >= 0 && yy < BH && xx >= 0 && xx < BW)
              s += kref[r*3+c] * img[yy*BW+xx];
          end
        s = s >>> sh;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        expv[y*BW+x] = s;
      end
  endfunction

  task automatic send_word(input logic [15:0] d, input bit is_coef);
    in_valid   = 1'b1;
    in_is_coef = is_coef;
    in_data    = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_coef(input int v);
    send_word(16'(v), 1'b1);
    kref[kptr] = int'($signed(16'(v)));
    kptr = (kptr == 8) ? 0 : kptr + 1;
  endtask

  task automatic send_pixels(input logic [7:0] upper);
    for (int i = 0; i < N; i++) send_word({upper, 8'(img[i])}, 1'b0);
    kptr = 0;
  endtask

  task automatic collect(input int stall, input string tag);
    int got = 0;
    int c = 0;
    bit held = 0;
    logic [7:0] hd = '0;
    logic hl = 1'b0;
    coll_done = 0;
    while (got < N) begin
      @(posedge clk); #1;
      out_ready = (stall == 0) || ((c % 3) != 1);
      c++;
      @(negedge clk);
      if (held)
        chk(out_valid && out_data == hd && out_last == hl, "R7 hold", int'(out_data), int'(hd));
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1; hd = out_data; hl = out_last;
      end
      if (out_valid && out_ready) begin
        chk(int'(out_data) == expv[got], tag, int'(out_data), expv[got]);
        chk(out_last == (got == N-1), "R6 last", int'(out_last), int'(got == N-1));
        got++;
        if (got == N) coll_done = 1;
      end
    end
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic run_block(input int stall, input logic [7:0] upper, input string tag);
    make_exp(int'(shift_amt));
    fork
      send_pixels(upper);
      collect(stall, tag);
    join
  endtask

  initial begin
    for (int t = 0; t < 9; t++) kref[t] = (t == 4) ? 1 : 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    @(posedge clk); #1;

    // R1 R3: identity kernel after reset, upper byte of pixel words ignored
    make_img(9);
    shift_amt = 4'd0;
    run_block(1, 8'hA5, "R1 R3 identity");

    // vector table: R2 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      for (int t = 0; t < 9; t++) send_coef(KTAB[v][t]);
      shift_amt = 4'(SHTAB[v]);
      make_img(SEEDT[v]);
      run_block(STALT[v], 8'h00, "R4 R5 vector");
    end

    // R2: tenth coefficient wraps to tap 0
    for (int t = 0; t < 9; t++) send_coef(t + 1);
    send_coef(-2);
    shift_amt = 4'd4;
    make_img(11);
    run_block(0, 8'h3C, "R2 wrap");

    // R2: partial load, then pixel data restarts write position at tap 0
    send_coef(5); send_coef(5); send_coef(5);
    shift_amt = 4'd2;
    make_img(12);
    run_block(1, 8'h00, "R2 partial");
    for (int t = 0; t < 9; t++) send_coef(KTAB[5][t]);
    shift_amt = 4'd0;
    make_img(13);
    run_block(0, 8'h00, "R2 restart");

    // R8 R9: kernel load right after a block is deferred and does not touch it
    make_img(14);
    shift_amt = 4'd1;
    make_exp(1);
    fork
      begin
        send_pixels(8'h00);
        in_valid = 1'b1; in_is_coef = 1'b1; in_data = 16'hFFFF;
        @(negedge clk);
        chk(in_ready == 1'b0, "R8 deferred", int'(in_ready), 0);
        send_word(16'hFFFF, 1'b1);
        chk(coll_done == 1'b1, "R8 after drain", int'(coll_done), 1);
        kref[kptr] = -1; kptr = 1;
        for (int t = 1; t < 9; t++) send_coef((t == 4) ? 8 : -1);
      end
      collect(1, "R9 old kernel");
    join
    make_img(15);
    run_block(0, 8'h00, "R9 new kernel");

    finish_run();
  end
endmodule